// File: doc/BRIEF.md
# Boot-or-Run Startup Decider

This block makes the power-up choice between staying in the boot loader and handing control to the application image. A start pulse opens a wait window: a countdown is loaded and, while it runs, every received byte is compared against two override codes. One code ends the window at once with the decision "stay in the loader". The other ends it at once with "run the image". If neither arrives before the countdown runs out, the decision is "run the image".

The window length depends on the link in use. Over the serial-port link the load value is a per-unit base count times a wait-time multiplier input. Over the SPI link it is a fixed short constant, and a slave-ready flag is raised for exactly as long as the window is open. The countdown steps once per prescaler tick, and all constants are parameters. The block does not parse frames and does not perform the jump. It only reports the decision with a one-cycle `done` pulse and a held `runImage` level.

Top module: `boot_decide`

## Requirements
- R1: After reset, `done`, `runImage` and `slaveReady` are all 0.
- R2: A start pulse while idle loads L = SPI_LOAD when `spiMode`=1, or L = UART_UNIT*`waitMult` when `spiMode`=0. With no override byte, `done` rises with `runImage`=1 exactly (L+1)*TICK_DIV clock edges after the edge that sampled start.
- R3: The count is tested for zero before it is decremented. A load value of 0 ends the window on the first tick, TICK_DIV edges after start.
- R4: A byte equal to BOOT_CODE (default 8'hF8) sampled with `rxValid`=1 during the window ends it at that edge with `runImage`=0.
- R5: A byte equal to RUN_CODE (default 8'h07) sampled with `rxValid`=1 during the window ends it at that edge with `runImage`=1.
- R6: Any other byte, and any byte while idle, is ignored. It neither ends the window nor reloads the count.
- R7: In SPI mode `slaveReady` is 1 from the edge after start until the decision edge, where it drops, whichever path decided. In serial-port mode it stays 0.
- R8: `done` is a one-cycle pulse. `runImage` changes only at a decision and holds its value until the next decision.
- R9: A start pulse during an open window is ignored and does not restart the count.
- R10: If BOOT_CODE arrives at the same edge where the count would expire, the decision is `runImage`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a wait window when idle |
| rxValid | input | 1 | Qualifies `rxData` for one cycle |
| rxData | input | BYTE_W | Received byte |
| spiMode | input | 1 | 1 = SPI link, 0 = serial-port link; sampled at start |
| waitMult | input | MULT_W | Wait-time multiplier for serial-port mode; sampled at start |
| done | output | 1 | One-cycle pulse when the decision is made |
| runImage | output | 1 | Decision: 1 = run image, 0 = stay in loader |
| slaveReady | output | 1 | SPI ready flag, high during an SPI window |

## Verification
The assertions check on every cycle that `done` never lasts two cycles, that `runImage` only moves together with `done`, and that `slaveReady` is never high in serial-port mode or at a decision. They also check that an override code seen inside the window produces the matching decision on the next cycle, with force-boot winning. The exact window lengths for both modes, the zero-load case, and the immunity to stray bytes and repeated start pulses depend on counted latencies. Only the bench scenarios, which predict the decision edge from the load value, can show those.

// File: rtl/boot_decide_pkg.sv
package boot_decide_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WAIT = 1'b1
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture load value, clear prescaler
    logic advance;  // let the prescaler run
    logic dec;      // step the countdown by one
  } dpStrobe_t;

endpackage

// File: rtl/boot_decide_dp.sv
module boot_decide_dp
  import boot_decide_pkg::*;
#(
  parameter int MULT_W    = 16,
  parameter int CNT_W     = 32,
  parameter int TICK_DIV  = 32,
  parameter int SPI_LOAD  = 56,
  parameter int UART_UNIT = 29490
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic              spiMode,
  input  logic [MULT_W-1:0] waitMult,
  output logic              tick,
  output logic              cntZero
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] SPI_VAL  = CNT_W'(SPI_LOAD);
  localparam logic [CNT_W-1:0] UNIT_VAL = CNT_W'(UART_UNIT);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    if (spiMode) loadVal = SPI_VAL;
    else         loadVal = CNT_W'(UNIT_VAL * CNT_W'(waitMult));
  end

  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pre <= '0;
        end else if (stb.load) begin
          pre <= '0;
        end else if (stb.advance) begin
          if (pre == PRE_LAST) pre <= '0;
          else                 pre <= pre + 1'b1;
        end
      end
      assign tick = (pre == PRE_LAST);
    end else begin : g_noprescale
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (stb.load) begin
      count <= loadVal;
    end else if (stb.dec) begin
      count <= count - 1'b1;
    end
  end

  assign cntZero = (count == '0);

endmodule

// File: rtl/boot_decide_ctrl.sv
module boot_decide_ctrl
  import boot_decide_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] BOOT_CODE = 8'hF8,
  parameter logic [BYTE_W-1:0] RUN_CODE  = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              spiMode,
  input  logic              tick,
  input  logic              cntZero,
  output dpStrobe_t         stb,
  output logic              waiting,
  output logic              modeSpi,
  output logic              done,
  output logic              runImage,
  output logic              slaveReady
);

  phase_t phase;
  logic   hitBoot;
  logic   hitRun;
  logic   expire;
  logic   decide;

  assign waiting = (phase == PH_WAIT);
  assign hitBoot = waiting && rxValid && (rxData == BOOT_CODE);
  assign hitRun  = waiting && rxValid && (rxData == RUN_CODE);
  assign expire  = waiting && tick && cntZero;
  assign decide  = hitBoot || hitRun || expire;

  always_comb begin
    stb         = '0;
    stb.load    = !waiting && start;
    stb.advance = waiting && !decide;
    stb.dec     = waiting && tick && !cntZero && !decide;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      modeSpi    <= 1'b0;
      done       <= 1'b0;
      runImage   <= 1'b0;
      slaveReady <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stb.load) begin
        phase      <= PH_WAIT;
        modeSpi    <= spiMode;
        slaveReady <= spiMode;
      end else if (decide) begin
        phase      <= PH_IDLE;
        done       <= 1'b1;
        runImage   <= !hitBoot;
        slaveReady <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/boot_decide.sv
module boot_decide
  import boot_decide_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MULT_W    = 16,
  parameter int CNT_W     = 32,
  parameter int TICK_DIV  = 32,
  parameter int SPI_LOAD  = 56,
  parameter int UART_UNIT = 29490,
  parameter logic [BYTE_W-1:0] BOOT_CODE = 8'hF8,
  parameter logic [BYTE_W-1:0] RUN_CODE  = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              spiMode,
  input  logic [MULT_W-1:0] waitMult,
  output logic              done,
  output logic              runImage,
  output logic              slaveReady
);

  dpStrobe_t stb;
  logic      tick;
  logic      cntZero;
  logic      waiting;
  logic      modeSpi;

  boot_decide_ctrl #(
    .BYTE_W(BYTE_W), .BOOT_CODE(BOOT_CODE), .RUN_CODE(RUN_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .rxValid(rxValid),
    .rxData(rxData), .spiMode(spiMode), .tick(tick), .cntZero(cntZero),
    .stb(stb), .waiting(waiting), .modeSpi(modeSpi), .done(done),
    .runImage(runImage), .slaveReady(slaveReady)
  );

  boot_decide_dp #(
    .MULT_W(MULT_W), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV),
    .SPI_LOAD(SPI_LOAD), .UART_UNIT(UART_UNIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .spiMode(spiMode),
    .waitMult(waitMult), .tick(tick), .cntZero(cntZero)
  );

endmodule

// File: rtl/boot_decide_chk.sv
module boot_decide_chk #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] BOOT_CODE = 8'hF8,
  parameter logic [BYTE_W-1:0] RUN_CODE  = 8'h07
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxValid,
  input logic [BYTE_W-1:0] rxData,
  input logic              waiting,
  input logic              modeSpi,
  input logic              done,
  input logic              runImage,
  input logic              slaveReady
);

  // R8: decision strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: the decision level moves only with the strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (runImage != $past(runImage)) |-> done);

  // R4, R10: force-boot code inside the window selects the loader
  a_r4_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && rxValid && rxData == BOOT_CODE) |=> (done && !runImage));

  // R5: force-run code inside the window selects the image
  a_r5_run: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && rxValid && rxData == RUN_CODE) |=> (done && runImage));

  // R7: ready flag never raised in serial-port mode
  a_r7_ready_uart: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !modeSpi) |-> !slaveReady);

  // R7: ready flag dropped at the decision
  a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !slaveReady);

  // R2: a decision only follows an open window
  a_r2_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(waiting));

endmodule

bind boot_decide boot_decide_chk #(
  .BYTE_W(BYTE_W), .BOOT_CODE(BOOT_CODE), .RUN_CODE(RUN_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxData(rxData),
  .waiting(waiting), .modeSpi(modeSpi), .done(done),
  .runImage(runImage), .slaveReady(slaveReady)
);

// File: tb/boot_decide_bench.sv
`timescale 1ns/1ps
module boot_decide_bench;

  localparam int TD    = 4;
  localparam int SPIL  = 3;
  localparam int UNIT  = 5;
  localparam logic [7:0] BOOT = 8'hF8;
  localparam logic [7:0] RUNC = 8'h07;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        spiMode = 1'b0;
  logic [15:0] waitMult = '0;
  logic        done, runImage, slaveReady;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    logic  run;
    int    lat;
    int    startEdge;
    string tag;
  } expItem_t;

  expItem_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  boot_decide #(
    .BYTE_W(8), .MULT_W(16), .CNT_W(32), .TICK_DIV(TD),
    .SPI_LOAD(SPIL), .UART_UNIT(UNIT), .BOOT_CODE(BOOT), .RUN_CODE(RUNC)
  ) u_boot_decide (
    .clk(clk), .rst_n(rst_n), .start(start), .rxValid(rxValid),
    .rxData(rxData), .spiMode(spiMode), .waitMult(waitMult),
    .done(done), .runImage(runImage), .slaveReady(slaveReady)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected decision when done appears
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R6/R8 unexpected done", 1, 0);
      end else begin
        expItem_t e;
        e = q.pop_front();
        check(runImage == e.run, {e.tag, " runImage"}, int'(runImage), int'(e.run));
        check((cyc - e.startEdge) == e.lat, {e.tag, " latency"},
              cyc - e.startEdge, e.lat);
        check(slaveReady == 1'b0, {"R7 ready low at decision ", e.tag},
              int'(slaveReady), 0);
      end
    end
  end

  // Driver: one wait window. byteAt<=0 means no override byte.
  task automatic doWait(input bit spi, input int mult, input int byteAt,
                        input logic [7:0] code, input bit noise,
                        input bit extraStart, input string tag);
    int ld, tmo, sEdge;
    expItem_t e;
    ld  = spi ? SPIL : UNIT * mult;
    tmo = (ld + 1) * TD;
    if (byteAt > 0 && byteAt <= tmo && code == BOOT) begin
      e.run = 1'b0; e.lat = byteAt;
    end else if (byteAt > 0 && byteAt <= tmo && code == RUNC) begin
      e.run = 1'b1; e.lat = byteAt;
    end else begin
      e.run = 1'b1; e.lat = tmo;
    end
    @(negedge clk);
    spiMode  = spi;
    waitMult = 16'(mult);
    start    = 1'b1;
    sEdge    = cyc + 1;
    e.startEdge = sEdge;
    e.tag = tag;
    q.push_back(e);
    for (int rel = 1; rel <= e.lat + 3; rel++) begin
      @(negedge clk);
      start   = (extraStart && rel == 5);
      rxValid = 1'b0;
      rxData  = 8'h00;
      if (rel == 3)
        check(slaveReady == spi, {"R7 ready during window ", tag},
              int'(slaveReady), int'(spi));
      if (rel == byteAt) begin
        rxValid = 1'b1; rxData = code;
      end else if (noise && (rel % 3 == 0)) begin
        rxValid = 1'b1; rxData = 8'h55;
      end
    end
    @(negedge clk);
    start = 1'b0; rxValid = 1'b0;
    check(runImage == e.run, {"R8 hold ", tag}, int'(runImage), int'(e.run));
    check(q.size() == 0, {"R2 decision seen ", tag}, q.size(), 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(runImage == 1'b0, "R1 runImage", int'(runImage), 0);
    check(slaveReady == 1'b0, "R1 slaveReady", int'(slaveReady), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    doWait(1'b0, 2, 0, 8'h00, 1'b0, 1'b0, "R2 uart timeout");
    doWait(1'b0, 0, 0, 8'h00, 1'b0, 1'b0, "R3 zero load");
    doWait(1'b1, 0, 0, 8'h00, 1'b0, 1'b0, "R2 R7 spi timeout");
    doWait(1'b0, 3, 20, BOOT, 1'b1, 1'b0, "R4 force boot");
    doWait(1'b1, 0, 7, RUNC, 1'b0, 1'b0, "R5 R7 spi force run");
    doWait(1'b0, 1, 0, 8'h00, 1'b1, 1'b1, "R6 R9 noise and restart");
    doWait(1'b0, 1, 24, BOOT, 1'b0, 1'b0, "R10 boot at expiry");
    doWait(1'b0, 4, 9, RUNC, 1'b1, 1'b0, "R5 uart force run");

    // R6: codes while idle do nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxData  = (i % 2 == 0) ? BOOT : RUNC;
    end
    @(negedge clk);
    rxValid = 1'b0;
    repeat (3) @(negedge clk);
    check(runImage == 1'b1, "R6 idle bytes ignored", int'(runImage), 1);
    check(slaveReady == 1'b0, "R7 idle ready low", int'(slaveReady), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule